// File: doc/BRIEF.md
# Adaptive Double-Error BCH Locator and Corrector

This block finishes the decode of a shortened binary BCH code over GF(2^9) that corrects up to two errors in a 274-bit word carrying 256 data bits. It is given the two odd syndromes S1 and S3 and the received word. It forms the discriminant R = S1^3 + S3 and a locator polynomial scaled by S1, so that no field inversion is needed. It then tests every codeword position against that polynomial in one combinational pass, flips the bits it locates, and returns the repaired data bits one clock later.

The single-error test depends only on S1 and S1^2, so it settles early. The double-error test adds one R-dependent term to the same single-error sum. R chooses which of the two hit vectors drives the correction. When the number of located roots does not match the chosen mode, the word is passed through untouched and a failure flag is raised.

Top module: `bch_dec_corrector`

## Requirements
- R1: Outputs are registered. `valid_o` is high exactly one cycle after `valid_i` is high. During reset `valid_o`, `corr_cnt_o` and `fail_o` are all 0.
- R2: If S1 = 0 and S3 = 0, the data passes through unchanged with `corr_cnt_o` = 0 and `fail_o` = 0.
- R3: If S1 != 0 and R = S1^3 + S3 = 0 (single-error mode), the single position j with alpha^j = S1 is flipped, and `corr_cnt_o` = 1.
- R4: If S1 != 0 and R != 0 (double-error mode), the two positions that are roots of S1 + S1^2·x + R·x^2 at x = alpha^(511-j) are flipped, and `corr_cnt_o` = 2.
- R5: In double-error mode, a root count other than 2 sets `fail_o` = 1 and `corr_cnt_o` = 0, and the data passes through unchanged.
- R6: In single-error mode, if no position in range is a root (S1 = alpha^j with j >= 274), `fail_o` = 1 and `corr_cnt_o` = 0, and the data passes through unchanged.
- R7: If S1 = 0 and S3 != 0, `fail_o` = 1 and `corr_cnt_o` = 0, and the data passes through unchanged.
- R8: The field is GF(2^9) with primitive polynomial x^9 + x^4 + 1 and alpha = 0x002. Codeword bit j (0..273) corresponds to alpha^j. `data_o` is `cw_i[273:18]`, after correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Syndromes and word are valid this cycle |
| s1_i | input | 9 | Syndrome S1 |
| s3_i | input | 9 | Syndrome S3 |
| cw_i | input | 274 | Received codeword, bit j at alpha^j |
| valid_o | output | 1 | Result valid |
| data_o | output | 256 | Corrected data bits |
| corr_cnt_o | output | 2 | Number of bits flipped (0, 1 or 2) |
| fail_o | output | 1 | Word could not be corrected; data passed through |

## Verification
The assertions check four things on every cycle:
- a single-error hit vector never has more than one bit set, and a double-error hit vector never more than two;
- a flipped count of 1 only follows R = 0, and a count of 2 only follows R != 0;
- a failed or clean word leaves the data bits untouched;
- the one-cycle valid latency holds.

Whether the right positions are flipped can only be shown by the bench. It builds real error patterns at the word's edges, at adjacent bits and at random positions, and compares the output with the original data. It also covers phantom locators that point past bit 273 and three-error words that alias into either mode.

// File: rtl/bch_loc_pkg.sv
package bch_loc_pkg;
  localparam int GF_M = 9;
  localparam int GF_Q = (1 << GF_M) - 1;
  localparam logic [GF_M-1:0] GF_RED = 9'h011;  // x^9 = x^4 + 1

  typedef enum logic [1:0] {MODE_CLEAN, MODE_SEC, MODE_DEC, MODE_BAD} dec_mode_e;

  function automatic logic [GF_M-1:0] gf_xtime(input logic [GF_M-1:0] a);
    return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_RED : '0);
  endfunction

  function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                             input logic [GF_M-1:0] b);
    logic [GF_M-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < GF_M; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // elaboration-time power of alpha
  function automatic logic [GF_M-1:0] alpha_pow(input int e);
    logic [GF_M-1:0] v;
    v = 1;
    for (int k = 0; k < GF_Q; k++) begin
      if (k < (e % GF_Q)) v = gf_xtime(v);
    end
    return v;
  endfunction
endpackage

// File: rtl/bch_r_calc.sv
module bch_r_calc
  import bch_loc_pkg::*;
(
  input  logic [GF_M-1:0] s1_i,
  input  logic [GF_M-1:0] s3_i,
  output logic [GF_M-1:0] s1sq_o,
  output logic [GF_M-1:0] r_o
);
  always_comb begin
    s1sq_o = gf_mul(s1_i, s1_i);
    r_o    = gf_mul(s1sq_o, s1_i) ^ s3_i;
  end
endmodule

// File: rtl/bch_chien_array.sv
module bch_chien_array
  import bch_loc_pkg::*;
#(
  parameter int N = 274
) (
  input  logic [GF_M-1:0] s1_i,
  input  logic [GF_M-1:0] s1sq_i,
  input  logic [GF_M-1:0] r_i,
  output logic [N-1:0]    hit_sec_o,
  output logic [N-1:0]    hit_dec_o
);
  logic s1_nz;
  assign s1_nz = |s1_i;

  for (genvar j = 0; j < N; j++) begin : g_pos
    localparam int E1 = (GF_Q - j) % GF_Q;
    localparam int E2 = (2 * E1) % GF_Q;
    localparam logic [GF_M-1:0] C1 = alpha_pow(E1);
    localparam logic [GF_M-1:0] C2 = alpha_pow(E2);
    logic [GF_M-1:0] sec_term, dec_term;
    always_comb begin
      sec_term     = s1_i ^ gf_mul(s1sq_i, C1);
      dec_term     = sec_term ^ gf_mul(r_i, C2);  // reuses the single-error sum
      hit_sec_o[j] = s1_nz && (sec_term == '0);
      hit_dec_o[j] = s1_nz && (dec_term == '0);
    end
  end
endmodule

// File: rtl/bch_sel_correct.sv
module bch_sel_correct
  import bch_loc_pkg::*;
#(
  parameter int N = 274,
  parameter int K = 256
) (
  input  logic [GF_M-1:0] s1_i,
  input  logic [GF_M-1:0] r_i,
  input  logic [N-1:0]    hit_sec_i,
  input  logic [N-1:0]    hit_dec_i,
  input  logic [N-1:0]    cw_i,
  output logic [K-1:0]    data_o,
  output logic [1:0]      cnt_o,
  output logic            fail_o
);
  localparam int P     = N - K;
  localparam int CNT_W = $clog2(N + 1);

  function automatic logic [CNT_W-1:0] popcnt(input logic [N-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int k = 0; k < N; k++) c = c + CNT_W'(v[k]);
    return c;
  endfunction

  dec_mode_e        mode;
  logic [N-1:0]     flip;
  logic [N-1:0]     fixed_cw;
  logic [CNT_W-1:0] n_sec, n_dec;

  always_comb begin
    n_sec = popcnt(hit_sec_i);
    n_dec = popcnt(hit_dec_i);
    if (s1_i == '0)
      mode = (r_i == '0) ? MODE_CLEAN : MODE_BAD;
    else if (r_i == '0)
      mode = (n_sec == CNT_W'(1)) ? MODE_SEC : MODE_BAD;
    else
      mode = (n_dec == CNT_W'(2)) ? MODE_DEC : MODE_BAD;

    unique case (mode)
      MODE_SEC: begin flip = hit_sec_i; cnt_o = 2'd1; end
      MODE_DEC: begin flip = hit_dec_i; cnt_o = 2'd2; end
      default:  begin flip = '0;        cnt_o = 2'd0; end
    endcase
    fail_o   = (mode == MODE_BAD);
    fixed_cw = cw_i ^ flip;
    data_o   = fixed_cw[N-1:P];
  end
endmodule

// File: rtl/bch_dec_corrector.sv
module bch_dec_corrector
  import bch_loc_pkg::*;
#(
  parameter int N = 274,
  parameter int K = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [GF_M-1:0] s1_i,
  input  logic [GF_M-1:0] s3_i,
  input  logic [N-1:0]    cw_i,
  output logic            valid_o,
  output logic [K-1:0]    data_o,
  output logic [1:0]      corr_cnt_o,
  output logic            fail_o
);
  localparam int P = N - K;

  logic [GF_M-1:0] s1sq_w, r_w;
  logic [N-1:0]    hit_sec_w, hit_dec_w;
  logic [K-1:0]    data_w;
  logic [1:0]      cnt_w;
  logic            fail_w;

  bch_r_calc u_rcalc (
    .s1_i  (s1_i),
    .s3_i  (s3_i),
    .s1sq_o(s1sq_w),
    .r_o   (r_w)
  );

  bch_chien_array #(.N(N)) u_chien (
    .s1_i     (s1_i),
    .s1sq_i   (s1sq_w),
    .r_i      (r_w),
    .hit_sec_o(hit_sec_w),
    .hit_dec_o(hit_dec_w)
  );

  bch_sel_correct #(.N(N), .K(K)) u_sel (
    .s1_i     (s1_i),
    .r_i      (r_w),
    .hit_sec_i(hit_sec_w),
    .hit_dec_i(hit_dec_w),
    .cw_i     (cw_i),
    .data_o   (data_w),
    .cnt_o    (cnt_w),
    .fail_o   (fail_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      data_o     <= '0;
      corr_cnt_o <= 2'd0;
      fail_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o     <= data_w;
        corr_cnt_o <= cnt_w;
        fail_o     <= fail_w;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_sec_single_root_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $onehot0(hit_sec_w));

  p_dec_two_roots_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($countones(hit_dec_w) <= 2));

  p_sec_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_w == 2'd1) |=> ($past(r_w) == '0 && $past(s1_i) != '0));

  p_dec_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_w == 2'd2) |=> ($past(r_w) != '0));

  p_fail_passthru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fail_w) |=> (data_o == $past(cw_i[N-1:P]) && corr_cnt_o == 2'd0));

  p_clean_passthru_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && s1_i == '0 && s3_i == '0) |=> (data_o == $past(cw_i[N-1:P]) && !fail_o));

  p_flip_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ($countones(data_o ^ $past(cw_i[N-1:P])) <= int'(corr_cnt_o)));
endmodule

// File: tb/tb_bch_dec_corrector.sv
`timescale 1ns/1ps
module tb_bch_dec_corrector;
  localparam int N = 274, K = 256, P = N - K;

  logic         clk = 0, rst_ni = 0, valid_i = 0;
  logic [8:0]   s1_i = 0, s3_i = 0;
  logic [N-1:0] cw_i = '0;
  logic         valid_o, fail_o;
  logic [K-1:0] data_o;
  logic [1:0]   corr_cnt_o;

  int errors = 0, checks = 0;
  logic [8:0] apow [0:510];

  always #2 clk = ~clk;

  bch_dec_corrector dut (.clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .s1_i(s1_i), .s3_i(s3_i), .cw_i(cw_i), .valid_o(valid_o), .data_o(data_o),
    .corr_cnt_o(corr_cnt_o), .fail_o(fail_o));

  function automatic logic [8:0] gm(input logic [8:0] a, input logic [8:0] b);
    logic [17:0] p;
    p = '0;
    for (int i = 0; i < 9; i++) if (b[i]) p = p ^ (18'(a) << i);
    for (int i = 17; i >= 9; i--) if (p[i]) p = p ^ (18'h211 << (i - 9));
    return p[8:0];
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [N-1:0] c, input logic [8:0] s1, input logic [8:0] s3,
                       output logic [K-1:0] d, output logic [1:0] n, output logic f);
    logic [8:0] r, e, v;
    logic [N-1:0] m;
    int cnt, want;
    r = gm(gm(s1, s1), s1) ^ s3;
    m = '0; cnt = 0;
    if (s1 == 0) begin
      d = c[N-1:P]; n = 0; f = (r != 0);
      return;
    end
    for (int j = 0; j < N; j++) begin
      e = apow[(511 - j) % 511];
      v = s1 ^ gm(gm(s1, s1), e);
      if (r != 0) v = v ^ gm(r, gm(e, e));
      if (v == 0) begin m[j] = 1'b1; cnt++; end
    end
    want = (r == 0) ? 1 : 2;
    if (cnt == want) begin
      m = c ^ m; d = m[N-1:P]; n = 2'(want); f = 0;
    end else begin
      d = c[N-1:P]; n = 0; f = 1;
    end
  endtask

  task automatic run(input string tag, input logic [N-1:0] c, input logic [8:0] s1,
                     input logic [8:0] s3, input logic [K-1:0] ed, input logic [1:0] en,
                     input logic ef);
    @(negedge clk);
    valid_i = 1; cw_i = c; s1_i = s1; s3_i = s3;
    @(negedge clk);
    valid_i = 0;
    chk({tag, " valid"}, 256'(valid_o), 256'(1));
    chk({tag, " data"}, 256'(data_o), 256'(ed));
    chk({tag, " cnt"}, 256'(corr_cnt_o), 256'(en));
    chk({tag, " fail"}, 256'(fail_o), 256'(ef));
  endtask

  // real error pattern: expected = original data, independent of locator math
  task automatic real_err(input string tag, input logic [N-1:0] orig, input logic [N-1:0] em);
    logic [8:0] s1, s3;
    int k;
    s1 = 0; s3 = 0; k = 0;
    for (int j = 0; j < N; j++)
      if (em[j]) begin s1 ^= apow[j]; s3 ^= apow[(3 * j) % 511]; k++; end
    run(tag, orig ^ em, s1, s3, orig[N-1:P], 2'(k), 1'b0);
  endtask

  function automatic logic [N-1:0] rnd_cw();
    logic [N-1:0] c;
    for (int w = 0; w < 9; w++) c[w*32 +: 32] = $urandom;
    c[N-1 -: 18] = 18'($urandom);
    return c;
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] o, em;
    logic [K-1:0] ed;
    logic [1:0] en;
    logic ef;
    logic [8:0] s1, s3;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0bc4);
    apow[0] = 9'h001;
    for (int i = 1; i < 511; i++) apow[i] = gm(apow[i-1], 9'h002);

    repeat (3) @(negedge clk);
    chk("R1 reset valid", 256'(valid_o), 256'(0));
    chk("R1 reset cnt", 256'(corr_cnt_o), 256'(0));
    chk("R1 reset fail", 256'(fail_o), 256'(0));
    rst_ni = 1;

    o = rnd_cw();
    real_err("R2 clean", o, '0);
    em = '0; em[0] = 1;   real_err("R3 single bit0", o, em);
    em = '0; em[273] = 1; real_err("R8 single top bit273", o, em);
    em = '0; em[18] = 1;  real_err("R3 single first data bit", o, em);
    em = '0; em[0] = 1; em[273] = 1;  real_err("R4 double edges", o, em);
    em = '0; em[17] = 1; em[18] = 1;  real_err("R4 double adjacent", o, em);
    @(negedge clk);
    chk("R1 valid drops", 256'(valid_o), 256'(0));

    run("R7 s1 zero s3 nonzero", o, 9'h000, apow[5], o[N-1:P], 2'd0, 1'b1);
    run("R6 phantom single j300", o, apow[300], apow[900 % 511], o[N-1:P], 2'd0, 1'b1);
    s1 = apow[10] ^ apow[400];
    s3 = apow[30] ^ apow[1200 % 511];
    run("R5 double one root out of range", o, s1, s3, o[N-1:P], 2'd0, 1'b1);

    for (int t = 0; t < 400; t++) begin
      int k, p;
      o = rnd_cw();
      k = $urandom_range(0, 3);
      em = '0;
      for (int e = 0; e < k; e++) begin
        do p = $urandom_range(0, N - 1); while (em[p]);
        em[p] = 1'b1;
      end
      if (k == 0)      real_err("R2 rand", o, em);
      else if (k == 1) real_err("R3 rand", o, em);
      else if (k == 2) real_err("R4 rand", o, em);
      else begin
        s1 = 0; s3 = 0;
        for (int j = 0; j < N; j++)
          if (em[j]) begin s1 ^= apow[j]; s3 ^= apow[(3 * j) % 511]; end
        model(o ^ em, s1, s3, ed, en, ef);
        run("R5 rand triple", o ^ em, s1, s3, ed, en, ef);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule